// File: doc/BRIEF.md
# Microcoded CHIP-8 Control Sequencer

This block is the control unit of a processor that runs CHIP-8 programs over a single shared data bus. Each 16-bit instruction is read from memory one byte at a time during two fetch microsteps. The two bytes are captured in an instruction latch and reduced by a pre-decoder to a 6-bit class code. A microstep counter then walks a microprogram. The microprogram is a constant table addressed by the class code, a latched ALU flag and the step number. Each entry is a 21-bit control word that tells the surrounding datapath which unit drives the bus and which unit loads from it.

Programs are variable in length. Each one ends on a step whose control word carries a terminate bit, and that step sends the counter back to step zero for the next fetch. Some steps take different actions depending on the latched flag. The counter can also be paced by hand: with step mode enabled, every rising edge of a step request moves it forward by exactly one step. The datapath itself is outside this block: the registers, the ALU, memory, the stack and the program counter. The block only emits the control word, a strobe that marks the cycles in which that word takes effect, and a clear request for the program counter.

Top module: `c8_useq`

## Requirements
- R1: While `rst` is high, `pc_clr` is 1 and `exec_en` is 0. On the first cycle after reset, `step_no` is 0 and `ctrl_word` holds the first fetch word: bits 19 (load high instruction byte), 17 (memory drives bus) and 16 (program counter increment) are set, and bit 20 (terminate) is clear.
- R2: Every instruction spends step 0 and step 1 on fetch, whatever the flag. Step 0 sets bit 19 and step 1 sets bit 18 (load low instruction byte). Both steps set bits 17 and 16. From step 2 onward, `instr` shows the byte read in step 0 as its high half and the byte read in step 1 as its low half.
- R3: The pre-decoder assigns these class codes, which `ins_class` shows from step 2 onward:
  - 8xy0 = 0x10, 8xy1 = 0x11, 8xy4 = 0x14
  - 3xkk = 0x05, 4xkk = 0x06
  - 00E0 = 0x01, Dxyn = 0x24, 1nnn = 0x03
  - Fx55 = 0x2E, Fx65 = 0x2F
  - any pattern outside the instruction set = 0x00
- R4: A program of length L runs steps 0 to L-1. Bit 20 is set only in step L-1, and the step after it is step 0. Each non-terminating advance adds exactly one to the step number. The lengths are:
  - 6 for 8xy0 to 8xy3
  - 7 for 8xy4 to 8xy7 and 8xyE
  - 8 for the four compare-and-skip forms
  - 46 for Fx55 and Fx65
  - 3 for undefined codes
  - 6 for every other defined class
- R5: For 8xy4, steps 2 to 5 run in this order:
  - step 2: register drive (bit 14) with select X (bits 12:11 = 0) and operand A load (bit 10)
  - step 3: register drive with select Y (1) and operand B load (bit 9)
  - step 4: ALU drive (bit 8), register write (bit 13) with select X, and flag latch (bit 4)
  - step 5: register write with select VF (2) and constant drive (bit 3)
- R6: In the step of 8xy4 that writes VF, constant bit 2 equals the latched flag. In steps 5 and 6 of a compare-and-skip, bit 16 is set only when the skip is taken. 3xkk and 5xy0 skip when the flag is 1; 4xkk and 9xy0 skip when the flag is 0.
- R7: The flag (`flag_out`) takes the value of `alu_flag` only on an advance whose word sets bit 4. Otherwise it keeps its value, and reset clears it.
- R8: With `step_mode` high, the counter and `exec_en` advance exactly once per rising edge of `step_req`, and the counter holds its value at all other times. With `step_mode` low, the counter advances on every cycle.
- R9: An undefined class runs only the two fetch steps and then a terminate step. That terminate step asserts neither register write (bit 13) nor program-counter load (bit 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_mode | input | 1 | 1 = advance only on step requests |
| step_req | input | 1 | Single-step request; its rising edge advances one step |
| bus_in | input | 8 | Byte on the shared bus, captured during fetch |
| alu_flag | input | 1 | ALU flag from the datapath, latched on flag-latch steps |
| ctrl_word | output | 21 | Control word of the current step (registered) |
| step_no | output | 6 | Current microstep number |
| ins_class | output | 6 | Class code of the current instruction |
| flag_out | output | 1 | Latched flag |
| instr | output | 16 | Latched instruction |
| exec_en | output | 1 | The current control word takes effect this cycle |
| pc_clr | output | 1 | Request to clear the program counter |

## Verification
The bench builds the block with the default widths: 6-bit class codes and 6-bit step numbers, giving a table of 8192 control words. With these widths the longest programs, the 46-step block transfers, fit inside the 64-step window. That puts the end-of-program return, both polarities of the flag-selected steps and the undefined-code path all within reach of a directed run. Each instruction is run from a fresh reset against a modelled memory and program counter. The bench compares class code, program length, instruction latch, flag and program-counter movement against values taken from the requirements.

// File: rtl/c8_useq_pkg.sv
package c8_useq_pkg;

  localparam int CLS_W  = 6;
  localparam int STEP_W = 6;
  localparam int LEN_W  = STEP_W + 1;

  localparam logic [CLS_W-1:0] CL_UNDEF = 6'h00;
  localparam logic [CLS_W-1:0] CL_CLS   = 6'h01;
  localparam logic [CLS_W-1:0] CL_RET   = 6'h02;
  localparam logic [CLS_W-1:0] CL_JP    = 6'h03;
  localparam logic [CLS_W-1:0] CL_CALL  = 6'h04;
  localparam logic [CLS_W-1:0] CL_SEQI  = 6'h05;
  localparam logic [CLS_W-1:0] CL_SNEI  = 6'h06;
  localparam logic [CLS_W-1:0] CL_SEQR  = 6'h07;
  localparam logic [CLS_W-1:0] CL_LDI   = 6'h08;
  localparam logic [CLS_W-1:0] CL_ADDI  = 6'h09;
  localparam logic [CLS_W-1:0] CL_ALU   = 6'h10;
  localparam logic [CLS_W-1:0] CL_SNER  = 6'h20;
  localparam logic [CLS_W-1:0] CL_LDIX  = 6'h21;
  localparam logic [CLS_W-1:0] CL_JPV   = 6'h22;
  localparam logic [CLS_W-1:0] CL_RND   = 6'h23;
  localparam logic [CLS_W-1:0] CL_DRAW  = 6'h24;
  localparam logic [CLS_W-1:0] CL_SKP   = 6'h25;
  localparam logic [CLS_W-1:0] CL_SKNP  = 6'h26;
  localparam logic [CLS_W-1:0] CL_GDT   = 6'h27;
  localparam logic [CLS_W-1:0] CL_KEY   = 6'h28;
  localparam logic [CLS_W-1:0] CL_SDT   = 6'h29;
  localparam logic [CLS_W-1:0] CL_SST   = 6'h2A;
  localparam logic [CLS_W-1:0] CL_ADDIX = 6'h2B;
  localparam logic [CLS_W-1:0] CL_FONT  = 6'h2C;
  localparam logic [CLS_W-1:0] CL_BCD   = 6'h2D;
  localparam logic [CLS_W-1:0] CL_STORE = 6'h2E;
  localparam logic [CLS_W-1:0] CL_LOAD  = 6'h2F;

  typedef enum logic [1:0] {SEL_X, SEL_Y, SEL_F, SEL_I} rsel_e;
  typedef enum logic [2:0] {FN_PASSB, FN_OR, FN_AND, FN_XOR,
                            FN_ADD, FN_SUB, FN_SHIFT, FN_CMP} afn_e;

  // Bit 20 down to bit 0
  typedef struct packed {
    logic  seq_done;
    logic  ir_hi_ld;
    logic  ir_lo_ld;
    logic  mem_oe;
    logic  pc_inc;
    logic  pc_ld;
    logic  reg_oe;
    logic  reg_we;
    rsel_e reg_sel;
    logic  opa_ld;
    logic  opb_ld;
    logic  alu_oe;
    afn_e  alu_fn;
    logic  flag_ld;
    logic  k_oe;
    logic  k_val;
    logic  imm_oe;
    logic  blk_next;
  } cw_t;

  localparam int CW_W = $bits(cw_t);

  function automatic afn_e alu_fn_of(input logic [3:0] n);
    case (n)
      4'h1:    return FN_OR;
      4'h2:    return FN_AND;
      4'h3:    return FN_XOR;
      4'h4:    return FN_ADD;
      4'h5:    return FN_SUB;
      4'h6:    return FN_SHIFT;
      4'h7:    return FN_SUB;
      4'hE:    return FN_SHIFT;
      default: return FN_PASSB;
    endcase
  endfunction

  function automatic logic is_skip(input logic [CLS_W-1:0] c);
    return (c == CL_SEQI) || (c == CL_SNEI) || (c == CL_SEQR) || (c == CL_SNER);
  endfunction

  function automatic logic [LEN_W-1:0] uc_len(input logic [CLS_W-1:0] c);
    if (c == CL_UNDEF) return 7'd3;
    if (c[5:4] == 2'b01) begin
      if (c[3:0] <= 4'h3) return 7'd6;
      if (c[3:0] <= 4'h7 || c[3:0] == 4'hE) return 7'd7;
      return 7'd3;
    end
    if (c > CL_ADDI && c < CL_ALU) return 7'd3;
    if (c > CL_LOAD) return 7'd3;
    if (is_skip(c)) return 7'd8;
    if (c == CL_STORE || c == CL_LOAD) return 7'd46;
    return 7'd6;
  endfunction

  function automatic cw_t uc_lookup(input logic [CLS_W-1:0] c, input logic fl,
                                    input logic [STEP_W-1:0] st);
    cw_t              w;
    logic [LEN_W-1:0] n;
    logic [STEP_W-1:0] ph;
    logic             take;
    w    = '0;
    n    = uc_len(c);
    ph   = (st - 6'd2) % 6'd3;
    take = (c == CL_SEQI || c == CL_SEQR) ? fl : ~fl;
    if (st == 6'd0) begin
      w.ir_hi_ld = 1'b1; w.mem_oe = 1'b1; w.pc_inc = 1'b1;
    end else if (st == 6'd1) begin
      w.ir_lo_ld = 1'b1; w.mem_oe = 1'b1; w.pc_inc = 1'b1;
    end else if ({1'b0, st} >= n - 7'd1) begin
      w.seq_done = 1'b1;
    end else if (c[5:4] == 2'b01) begin
      w.alu_fn = alu_fn_of(c[3:0]);
      case (st)
        6'd2: begin w.reg_oe = 1'b1; w.reg_sel = SEL_X; w.opa_ld = 1'b1; end
        6'd3: begin w.reg_oe = 1'b1; w.reg_sel = SEL_Y; w.opb_ld = 1'b1; end
        6'd4: begin
          w.alu_oe = 1'b1; w.reg_we = 1'b1; w.reg_sel = SEL_X;
          w.flag_ld = (n == 7'd7);
        end
        default: begin
          w.reg_we = 1'b1; w.reg_sel = SEL_F; w.k_oe = 1'b1; w.k_val = fl;
        end
      endcase
    end else if (is_skip(c)) begin
      case (st)
        6'd2: begin w.reg_oe = 1'b1; w.reg_sel = SEL_X; w.opa_ld = 1'b1; end
        6'd3: begin
          w.opb_ld = 1'b1;
          if (c == CL_SEQR || c == CL_SNER) begin
            w.reg_oe = 1'b1; w.reg_sel = SEL_Y;
          end else begin
            w.imm_oe = 1'b1;
          end
        end
        6'd4:    begin w.alu_fn = FN_CMP; w.flag_ld = 1'b1; end
        default: w.pc_inc = take;
      endcase
    end else if (c == CL_STORE || c == CL_LOAD) begin
      case (ph)
        6'd0: begin w.reg_oe = 1'b1; w.reg_sel = SEL_I; end
        6'd1: begin
          w.reg_sel = SEL_X;
          if (c == CL_STORE) w.reg_oe = 1'b1;
          else begin w.mem_oe = 1'b1; w.reg_we = 1'b1; end
        end
        default: w.blk_next = 1'b1;
      endcase
    end else begin
      case (st)
        6'd2:    begin w.reg_oe = 1'b1; w.reg_sel = SEL_X; w.opa_ld = 1'b1; end
        6'd3:    begin w.imm_oe = 1'b1; w.opb_ld = 1'b1; w.alu_fn = FN_ADD; end
        default: begin
          w.alu_oe = 1'b1; w.reg_we = 1'b1; w.reg_sel = SEL_X; w.alu_fn = FN_ADD;
        end
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/c8_predecode.sv
module c8_predecode
  import c8_useq_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic [INSTR_W-1:0] instr,
  output logic [CLS_W-1:0]   cls
);
  localparam int OP_LSB = INSTR_W - 4;

  logic [3:0] op;
  logic [3:0] nib;
  logic [7:0] lo8;

  assign op  = instr[INSTR_W-1:OP_LSB];
  assign nib = instr[3:0];
  assign lo8 = instr[7:0];

  always_comb begin
    cls = CL_UNDEF;
    case (op)
      4'h0: begin
        if (instr == 16'h00E0)      cls = CL_CLS;
        else if (instr == 16'h00EE) cls = CL_RET;
      end
      4'h1: cls = CL_JP;
      4'h2: cls = CL_CALL;
      4'h3: cls = CL_SEQI;
      4'h4: cls = CL_SNEI;
      4'h5: if (nib == 4'h0) cls = CL_SEQR;
      4'h6: cls = CL_LDI;
      4'h7: cls = CL_ADDI;
      4'h8: if (nib <= 4'h7 || nib == 4'hE) cls = {2'b01, nib};
      4'h9: if (nib == 4'h0) cls = CL_SNER;
      4'hA: cls = CL_LDIX;
      4'hB: cls = CL_JPV;
      4'hC: cls = CL_RND;
      4'hD: cls = CL_DRAW;
      4'hE: begin
        if (lo8 == 8'h9E)      cls = CL_SKP;
        else if (lo8 == 8'hA1) cls = CL_SKNP;
      end
      default: begin
        case (lo8)
          8'h07:   cls = CL_GDT;
          8'h0A:   cls = CL_KEY;
          8'h15:   cls = CL_SDT;
          8'h18:   cls = CL_SST;
          8'h1E:   cls = CL_ADDIX;
          8'h29:   cls = CL_FONT;
          8'h33:   cls = CL_BCD;
          8'h55:   cls = CL_STORE;
          8'h65:   cls = CL_LOAD;
          default: cls = CL_UNDEF;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/c8_ustep_ctr.sv
module c8_ustep_ctr #(
  parameter int STEP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_mode,
  input  logic              step_req,
  input  logic              done,
  output logic              adv,
  output logic [STEP_W-1:0] step_q,
  output logic [STEP_W-1:0] step_d
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= step_req;
  end

  assign adv = ~rst & (step_mode ? (step_req & ~req_q) : 1'b1);

  always_comb begin
    if (rst)                     step_d = '0;
    else if (!adv)               step_d = step_q;
    else if (done || (&step_q))  step_d = '0;
    else                         step_d = step_q + 1'b1;
  end

  always_ff @(posedge clk) step_q <= step_d;

  // R4
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && done) |=> (step_q == '0));

  // R4
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !done && !(&step_q)) |=> (step_q == $past(step_q) + 1'b1));

  // R8
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(step_q));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (step_mode && adv) |=> (!adv || !step_mode));
endmodule

// File: rtl/c8_ucode_rom.sv
module c8_ucode_rom
  import c8_useq_pkg::*;
#(
  parameter int C_W = CLS_W,
  parameter int S_W = STEP_W
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic [C_W+S_W:0]     addr,
  output logic [CW_W-1:0]      data_q
);
  localparam int ADDR_W = C_W + S_W + 1;
  localparam int FL_BIT = S_W;

  logic [C_W-1:0] a_cls;
  logic           a_fl;
  logic [S_W-1:0] a_st;

  assign a_cls = addr[ADDR_W-1:FL_BIT+1];
  assign a_fl  = addr[FL_BIT];
  assign a_st  = addr[S_W-1:0];

  always_ff @(posedge clk) begin
    if (en) data_q <= uc_lookup(a_cls, a_fl, a_st);
  end
endmodule

// File: rtl/c8_useq.sv
module c8_useq
  import c8_useq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_mode,
  input  logic                step_req,
  input  logic [BYTE_W-1:0]   bus_in,
  input  logic                alu_flag,
  output logic [CW_W-1:0]     ctrl_word,
  output logic [STEP_W-1:0]   step_no,
  output logic [CLS_W-1:0]    ins_class,
  output logic                flag_out,
  output logic [2*BYTE_W-1:0] instr,
  output logic                exec_en,
  output logic                pc_clr
);
  localparam int ADDR_W = CLS_W + STEP_W + 1;

  logic [BYTE_W-1:0]  ir_hi_q, ir_lo_q;
  logic [CLS_W-1:0]   cls_q, cls_d, cls_nxt;
  logic               flag_q, flag_d;
  logic               adv;
  logic [STEP_W-1:0]  step_q, step_d;
  logic [CW_W-1:0]    rom_q;
  logic [ADDR_W-1:0]  rom_addr;
  cw_t                cw;

  assign cw = cw_t'(rom_q);

  c8_predecode #(.INSTR_W(2*BYTE_W)) u_pdec (
    .instr ({ir_hi_q, bus_in}),
    .cls   (cls_nxt)
  );

  c8_ustep_ctr #(.STEP_W(STEP_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .step_mode (step_mode),
    .step_req  (step_req),
    .done      (cw.seq_done),
    .adv       (adv),
    .step_q    (step_q),
    .step_d    (step_d)
  );

  assign cls_d  = (adv && cw.ir_lo_ld) ? cls_nxt  : cls_q;
  assign flag_d = (adv && cw.flag_ld)  ? alu_flag : flag_q;

  assign rom_addr = rst ? '0 : {cls_d, flag_d, step_d};

  c8_ucode_rom #(.C_W(CLS_W), .S_W(STEP_W)) u_rom (
    .clk    (clk),
    .en     (rst | adv),
    .addr   (rom_addr),
    .data_q (rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_hi_q <= '0;
      ir_lo_q <= '0;
      cls_q   <= CL_UNDEF;
      flag_q  <= 1'b0;
    end else begin
      if (adv && cw.ir_hi_ld) ir_hi_q <= bus_in;
      if (adv && cw.ir_lo_ld) ir_lo_q <= bus_in;
      cls_q  <= cls_d;
      flag_q <= flag_d;
    end
  end

  assign ctrl_word = rom_q;
  assign step_no   = step_q;
  assign ins_class = cls_q;
  assign flag_out  = flag_q;
  assign instr     = {ir_hi_q, ir_lo_q};
  assign exec_en   = adv;
  assign pc_clr    = rst;

  // R2
  fetch_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == 6'd1) |-> (cw.ir_lo_ld && cw.mem_oe && cw.pc_inc && !cw.seq_done));

  // R2
  fetch_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == 6'd0) |-> (cw.ir_hi_ld && cw.mem_oe && cw.pc_inc));

  // R9
  undef_end_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == 6'd2 && cls_q == CL_UNDEF) |-> (cw.seq_done && !cw.reg_we && !cw.pc_ld));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(adv && cw.flag_ld) |=> $stable(flag_q));
endmodule

// File: tb/c8_useq_tb.sv
module c8_useq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  // {instr, flag nibble, class byte, length byte, pc delta byte}
  localparam logic [43:0] VEC [NV] = '{
    {16'h8120, 4'h0, 8'h10, 8'd6,  8'd2},
    {16'h8121, 4'h1, 8'h11, 8'd6,  8'd2},
    {16'h8124, 4'h0, 8'h14, 8'd7,  8'd2},
    {16'h8124, 4'h1, 8'h14, 8'd7,  8'd2},
    {16'h3A55, 4'h1, 8'h05, 8'd8,  8'd4},
    {16'h3A55, 4'h0, 8'h05, 8'd8,  8'd2},
    {16'h4A55, 4'h0, 8'h06, 8'd8,  8'd4},
    {16'h4A55, 4'h1, 8'h06, 8'd8,  8'd2},
    {16'hF355, 4'h0, 8'h2E, 8'd46, 8'd2},
    {16'hF365, 4'h1, 8'h2F, 8'd46, 8'd2},
    {16'h8128, 4'h0, 8'h00, 8'd3,  8'd2},
    {16'h5121, 4'h1, 8'h00, 8'd3,  8'd2},
    {16'h00E0, 4'h0, 8'h01, 8'd6,  8'd2},
    {16'hD125, 4'h0, 8'h24, 8'd6,  8'd2},
    {16'h1234, 4'h0, 8'h03, 8'd6,  8'd2},
    {16'h0123, 4'h0, 8'h00, 8'd3,  8'd2},
    {16'hFA07, 4'h1, 8'h27, 8'd6,  8'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_mode = 1'b0;
  logic        step_req = 1'b0;
  logic [7:0]  bus_in;
  logic        alu_flag = 1'b0;
  logic [20:0] ctrl_word;
  logic [5:0]  step_no;
  logic [5:0]  ins_class;
  logic        flag_out;
  logic [15:0] instr;
  logic        exec_en;
  logic        pc_clr;

  logic [7:0]  mem [0:255];
  logic [7:0]  pc;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  c8_useq u_dut (
    .clk(clk), .rst(rst), .step_mode(step_mode), .step_req(step_req),
    .bus_in(bus_in), .alu_flag(alu_flag), .ctrl_word(ctrl_word),
    .step_no(step_no), .ins_class(ins_class), .flag_out(flag_out),
    .instr(instr), .exec_en(exec_en), .pc_clr(pc_clr)
  );

  assign bus_in = mem[pc];

  always_ff @(posedge clk) begin
    if (pc_clr)                       pc <= 8'd0;
    else if (exec_en && ctrl_word[16]) pc <= pc + 8'd1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit latches_flag(input logic [5:0] c);
    return (c == 6'h14 || c == 6'h15 || c == 6'h16 || c == 6'h17 || c == 6'h1E ||
            c == 6'h05 || c == 6'h06 || c == 6'h07 || c == 6'h20);
  endfunction

  task automatic load_and_reset(input logic [15:0] ins, input logic fl, input logic sm);
    @(negedge clk);
    rst = 1'b1;
    step_mode = sm;
    step_req = 1'b0;
    mem[0] = ins[15:8];
    mem[1] = ins[7:0];
    alu_flag = fl;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_vec(input logic [43:0] v);
    logic [15:0] ins;
    logic        fl;
    logic [5:0]  ecls;
    int          elen, epcd, len;
    bit          seen_done;
    ins  = v[43:28];
    fl   = v[24];
    ecls = v[21:16];
    elen = int'(v[15:8]);
    epcd = int'(v[7:0]);
    len  = 0;
    seen_done = 1'b0;
    load_and_reset(ins, fl, 1'b0);
    for (int c = 0; c < 80; c++) begin
      if (step_no == 6'd2) begin
        chk(ins_class == ecls, "R3", "class", ins_class, ecls);
        chk(instr == ins, "R2", "instr latch", instr, ins);
        if (ecls == 6'h00)
          chk(ctrl_word[13] == 1'b0 && ctrl_word[15] == 1'b0, "R9",
              "undefined end writes", ctrl_word[15:13], 0);
      end
      if (ecls == 6'h14) begin
        case (step_no)
          6'd2: chk(ctrl_word[14] && ctrl_word[12:11] == 2'd0 && ctrl_word[10], "R5",
                    "add step2", ctrl_word, 0);
          6'd3: chk(ctrl_word[14] && ctrl_word[12:11] == 2'd1 && ctrl_word[9], "R5",
                    "add step3", ctrl_word, 0);
          6'd4: chk(ctrl_word[8] && ctrl_word[13] && ctrl_word[12:11] == 2'd0 &&
                    ctrl_word[4], "R5", "add step4", ctrl_word, 0);
          6'd5: begin
            chk(ctrl_word[13] && ctrl_word[12:11] == 2'd2 && ctrl_word[3], "R5",
                "add step5", ctrl_word, 0);
            chk(ctrl_word[2] == fl, "R6", "VF constant", ctrl_word[2], fl);
          end
          default: ;
        endcase
      end
      if (ctrl_word[20]) begin
        len = int'(step_no) + 1;
        seen_done = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk(seen_done && len == elen, "R4", "program length", len, elen);
    chk(int'(pc) == epcd, "R6", "pc advance", pc, epcd);
    chk(flag_out == (latches_flag(ecls) ? fl : 1'b0), "R7", "latched flag",
        flag_out, latches_flag(ecls) ? fl : 1'b0);
    @(negedge clk);
    chk(step_no == 6'd0 && ctrl_word[19], "R4", "return to fetch", step_no, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    // R1: reset state
    load_and_reset(16'h8124, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk(pc_clr == 1'b1, "R1", "pc_clr in reset", pc_clr, 1);
    chk(exec_en == 1'b0, "R1", "exec_en in reset", exec_en, 0);
    chk(step_no == 6'd0, "R1", "step in reset", step_no, 0);
    rst = 1'b0;
    chk(ctrl_word[19] && ctrl_word[17] && ctrl_word[16] && !ctrl_word[20], "R1",
        "fetch word after reset", ctrl_word, 21'h0B0000);
    @(negedge clk);
    chk(step_no == 6'd1 && ctrl_word[18] && ctrl_word[17] && ctrl_word[16], "R2",
        "second fetch word", ctrl_word, 21'h070000);

    // Table of instruction vectors
    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R8: single-step mode
    load_and_reset(16'h8124, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    chk(step_no == 6'd0, "R8", "hold without request", step_no, 0);
    chk(exec_en == 1'b0, "R8", "no strobe without request", exec_en, 0);
    step_req = 1'b1;
    repeat (4) @(negedge clk);
    chk(step_no == 6'd1, "R8", "one step per pulse", step_no, 1);
    step_req = 1'b0;
    @(negedge clk);
    step_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(step_no == 6'd2, "R8", "second pulse", step_no, 2);
    chk(ins_class == 6'h14, "R3", "class in step mode", ins_class, 6'h14);
    step_req = 1'b0;
    step_mode = 1'b0;
    @(negedge clk);
    chk(step_no == 6'd3, "R8", "free run resumes", step_no, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule